// File: doc/BRIEF.md
# IR Controller Interrupt Status Register

This block holds the interrupt status byte of an infrared serial controller running in its advanced modes, and drives the single interrupt request line. It collects five event sources: a countdown timer that reached zero, the frame status FIFO level or its timeout, the transmit FIFO threshold, a DMA terminal count on either channel, and a change of the handshake status register. Each source follows its own set and clear rule. Two bits follow a FIFO level and do not latch. Others latch until this register is read. The handshake bit latches until the handshake status register is read instead.

The surrounding controller feeds in event strobes, FIFO levels with their thresholds, gating enables and the read strobes of the two registers. It reads back `status_o`. A five-bit interrupt enable word, written through `ien_we_i`, selects which status bits may raise `irq_o`. For the legacy-compatible identification view, a small priority encoder turns four receive/transmit conditions into a four-bit identification code.

Top module: `ir_int_status`

## Requirements
- R1: The reset input clears every status bit, `irq_o` and the stored interrupt enables. The clear happens at once when reset is asserted and is still in effect after reset is released.
- R2: Status bit 7 (timer) sets after a `tmr_zero_i` strobe only when `tmr_run_en_i` and `tmr_irq_en_i` are both 1. It then holds until an `isr_rd_i` strobe clears it.
- R3: Status bit 6 (frame status FIFO) is 1 in the cycle after `fsf_level_i >= fsf_thresh_i` and 0 after the level falls below the threshold. A `fsf_timeout_i` strobe also sets it, and that cause holds until an `isr_rd_i` strobe.
- R4: Status bit 5 (transmit threshold) is 1 in the cycle after `txf_level_i < txf_thresh_i`. It is 0 after the level is equal to or above the threshold. It never latches.
- R5: Status bit 4 (DMA) sets after a `dma_tc_tx_i` or `dma_tc_rx_i` strobe and holds until an `isr_rd_i` strobe clears it.
- R6: Status bit 3 (handshake) sets after a `hs_toggle_i` strobe and is cleared by `hsr_rd_i`. An `isr_rd_i` strobe does not clear it.
- R7: While `hs_enable_i` is 0, a handshake toggle leaves bit 3 at 0. Dropping `hs_enable_i` discards a pending handshake event, so it does not return when the enable is raised again.
- R8: While `bit3_en_i` is 0, status bit 3 reads 0 and cannot raise `irq_o`. A latched handshake event is kept and shows again once `bit3_en_i` is 1.
- R9: When a set event and its clearing read arrive in the same cycle, the bit ends up set.
- R10: `irq_o` is the OR over status bits 7..3, each ANDed with its enable. Enable bit k gates status bit k+3, so enable bit 4 is the timer and enable bit 2 is the transmit threshold. A write with `ien_we_i` takes effect from the next cycle.
- R11: `ident_o` reports 0110 for `rx_err_i`, else 0100 for `rx_rdy_i`, else 1100 for `rx_tmo_i`, else 0010 for `tx_emp_i`, else 0001. The conditions are listed in falling priority.
- R12: Status bits 2..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_zero_i | input | 1 | Strobe: countdown timer reached zero |
| tmr_run_en_i | input | 1 | Timer running enable |
| tmr_irq_en_i | input | 1 | Timer interrupt enable |
| fsf_level_i | input | LVL_W | Frame status FIFO fill level |
| fsf_thresh_i | input | LVL_W | Frame status FIFO threshold |
| fsf_timeout_i | input | 1 | Strobe: frame status FIFO timeout |
| txf_level_i | input | LVL_W | Transmit FIFO fill level |
| txf_thresh_i | input | LVL_W | Transmit FIFO threshold |
| dma_tc_tx_i | input | 1 | Strobe: transmit channel terminal count |
| dma_tc_rx_i | input | 1 | Strobe: receive channel terminal count |
| hs_toggle_i | input | 1 | Strobe: handshake status register changed |
| hs_enable_i | input | 1 | IR handshake status enable |
| bit3_en_i | input | 1 | Control bit that makes status bit 3 visible |
| isr_rd_i | input | 1 | Strobe: this status register is read |
| hsr_rd_i | input | 1 | Strobe: handshake status register is read |
| ien_we_i | input | 1 | Write strobe for the interrupt enable word |
| ien_wdata_i | input | 5 | Interrupt enable word (bit k gates status bit k+3) |
| rx_err_i | input | 1 | Legacy view: receive status error pending |
| rx_rdy_i | input | 1 | Legacy view: receive data ready |
| rx_tmo_i | input | 1 | Legacy view: receive FIFO data timeout |
| tx_emp_i | input | 1 | Legacy view: transmit buffer empty |
| status_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request |
| ident_o | output | 4 | Legacy identification code |

## Verification
The level-tracking bits are driven with FIFO levels below, equal to and above the threshold. This separates an at-or-above compare from a strictly-above compare and a below compare from a not-above compare. Each latched bit is sent its own read strobe, the other register's read strobe and a coincident set and read. The results show which read clears which bit and that a set is never lost. The gating inputs are toggled while an event is pending, to show that a masked bit is hidden rather than dropped and that a dropped enable discards the event. The enable word is rewritten with a status bit standing, which shows that the mask selects bits and is not a global enable. The identification view is given overlapping conditions to fix its priority order.

// File: rtl/ir_isr_pkg.sv
package ir_isr_pkg;
  localparam int NSRC   = 5;
  localparam int STAT_W = 8;
  localparam int B_TMR  = 7;
  localparam int B_FSF  = 6;
  localparam int B_TXT  = 5;
  localparam int B_DMA  = 4;
  localparam int B_HS   = 3;
  localparam int B_LOW  = B_HS;   // lowest used status bit

  localparam int NLATCH = 4;
  localparam int LT_TMR = 0;
  localparam int LT_FTO = 1;
  localparam int LT_DMA = 2;
  localparam int LT_HS  = 3;

  typedef enum logic [3:0] {
    ID_NONE   = 4'b0001,
    ID_RXSTAT = 4'b0110,
    ID_RXRDY  = 4'b0100,
    ID_RXTMO  = 4'b1100,
    ID_TXEMP  = 4'b0010
  } ident_e;
endpackage

// File: rtl/isr_rst_sync.sv
module isr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/isr_evt_latch.sv
module isr_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic gate_i,
  output logic q_o
);
  logic q_q;
  logic q_d;

  // set has priority over clear; gate low discards the event
  always_comb begin
    q_d = gate_i & (set_i | (q_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && gate_i) |=> q_o); // R9
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R5
  AST_GATE_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i) |=> !q_o); // R7
endmodule

// File: rtl/isr_lvl_flag.sv
module isr_lvl_flag #(
  parameter int LVL_W       = 5,
  parameter bit AT_OR_ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             q_o
);
  logic q_q;
  logic q_d;

  generate
    if (AT_OR_ABOVE) begin : g_ge
      always_comb q_d = (lvl_i >= thr_i);
    end else begin : g_lt
      always_comb q_d = (lvl_i < thr_i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/isr_ident_enc.sv
module isr_ident_enc
  import ir_isr_pkg::*;
(
  input  logic       rx_err_i,
  input  logic       rx_rdy_i,
  input  logic       rx_tmo_i,
  input  logic       tx_emp_i,
  output logic [3:0] ident_o
);
  ident_e code;

  always_comb begin
    if (rx_err_i)      code = ID_RXSTAT;
    else if (rx_rdy_i) code = ID_RXRDY;
    else if (rx_tmo_i) code = ID_RXTMO;
    else if (tx_emp_i) code = ID_TXEMP;
    else               code = ID_NONE;
  end

  assign ident_o = code;
endmodule

// File: rtl/ir_int_status.sv
module ir_int_status
  import ir_isr_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero_i,
  input  logic             tmr_run_en_i,
  input  logic             tmr_irq_en_i,
  input  logic [LVL_W-1:0] fsf_level_i,
  input  logic [LVL_W-1:0] fsf_thresh_i,
  input  logic             fsf_timeout_i,
  input  logic [LVL_W-1:0] txf_level_i,
  input  logic [LVL_W-1:0] txf_thresh_i,
  input  logic             dma_tc_tx_i,
  input  logic             dma_tc_rx_i,
  input  logic             hs_toggle_i,
  input  logic             hs_enable_i,
  input  logic             bit3_en_i,
  input  logic             isr_rd_i,
  input  logic             hsr_rd_i,
  input  logic             ien_we_i,
  input  logic [NSRC-1:0]  ien_wdata_i,
  input  logic             rx_err_i,
  input  logic             rx_rdy_i,
  input  logic             rx_tmo_i,
  input  logic             tx_emp_i,
  output logic [STAT_W-1:0] status_o,
  output logic             irq_o,
  output logic [3:0]       ident_o
);
  logic              rst_s;
  logic [NLATCH-1:0] lt_set;
  logic [NLATCH-1:0] lt_clr;
  logic [NLATCH-1:0] lt_gate;
  logic [NLATCH-1:0] lt_q;
  logic              fsf_at;
  logic              txf_below;
  logic [NSRC-1:0]   ien_q;
  logic [NSRC-1:0]   ien_d;
  logic [STAT_W-1:0] stat;

  isr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_s)
  );

  // per-latch set, clear and gate rules
  always_comb begin
    lt_set[LT_TMR]  = tmr_zero_i & tmr_run_en_i & tmr_irq_en_i;
    lt_clr[LT_TMR]  = isr_rd_i;
    lt_gate[LT_TMR] = 1'b1;
    lt_set[LT_FTO]  = fsf_timeout_i;
    lt_clr[LT_FTO]  = isr_rd_i;
    lt_gate[LT_FTO] = 1'b1;
    lt_set[LT_DMA]  = dma_tc_tx_i | dma_tc_rx_i;
    lt_clr[LT_DMA]  = isr_rd_i;
    lt_gate[LT_DMA] = 1'b1;
    lt_set[LT_HS]   = hs_toggle_i;
    lt_clr[LT_HS]   = hsr_rd_i;
    lt_gate[LT_HS]  = hs_enable_i;
  end

  generate
    for (genvar i = 0; i < NLATCH; i++) begin : g_lt
      isr_evt_latch u_lt (
        .clk(clk), .rst_n(rst_s),
        .set_i(lt_set[i]), .clr_i(lt_clr[i]), .gate_i(lt_gate[i]),
        .q_o(lt_q[i])
      );
    end
  endgenerate

  isr_lvl_flag #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)) u_fsf (
    .clk(clk), .rst_n(rst_s), .lvl_i(fsf_level_i), .thr_i(fsf_thresh_i),
    .q_o(fsf_at)
  );

  isr_lvl_flag #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)) u_txf (
    .clk(clk), .rst_n(rst_s), .lvl_i(txf_level_i), .thr_i(txf_thresh_i),
    .q_o(txf_below)
  );

  // interrupt enable word: next-state and register
  always_comb begin
    ien_d = ien_we_i ? ien_wdata_i : ien_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ien_q <= '0;
    else        ien_q <= ien_d;
  end

  always_comb begin
    stat        = '0;
    stat[B_TMR] = lt_q[LT_TMR];
    stat[B_FSF] = fsf_at | lt_q[LT_FTO];
    stat[B_TXT] = txf_below;
    stat[B_DMA] = lt_q[LT_DMA];
    stat[B_HS]  = lt_q[LT_HS] & bit3_en_i;
  end

  assign status_o = stat;
  assign irq_o    = |(stat[STAT_W-1:B_LOW] & ien_q);

  isr_ident_enc u_id (
    .rx_err_i(rx_err_i), .rx_rdy_i(rx_rdy_i), .rx_tmo_i(rx_tmo_i),
    .tx_emp_i(tx_emp_i), .ident_o(ident_o)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_s)
    (ien_q == '0) |-> !irq_o); // R10
  AST_BIT3_HIDDEN: assert property (@(posedge clk) disable iff (!rst_s)
    (!bit3_en_i) |-> !status_o[B_HS]); // R8
  AST_TX_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_s)
    (txf_level_i >= txf_thresh_i) |=> !status_o[B_TXT]); // R4
  AST_FSF_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_s)
    (fsf_level_i >= fsf_thresh_i) |=> status_o[B_FSF]); // R3
  AST_TMR_GATED: assert property (@(posedge clk) disable iff (!rst_s)
    (!(tmr_run_en_i && tmr_irq_en_i) && !status_o[B_TMR]) |=> !status_o[B_TMR]); // R2
  AST_HS_KEEPS_ON_ISR: assert property (@(posedge clk) disable iff (!rst_s)
    (status_o[B_HS] && !hsr_rd_i && hs_enable_i && bit3_en_i) |=> status_o[B_HS]); // R6
endmodule

// File: tb/sim_ir_int_status.sv
module sim_ir_int_status;
  localparam int LVL_W = 5;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic tmr_zero, tmr_run_en, tmr_irq_en;
  logic [LVL_W-1:0] fsf_level, fsf_thresh, txf_level, txf_thresh;
  logic fsf_timeout, dma_tc_tx, dma_tc_rx, hs_toggle, hs_enable, bit3_en;
  logic isr_rd, hsr_rd, ien_we;
  logic [4:0] ien_wdata;
  logic rx_err, rx_rdy, rx_tmo, tx_emp;
  logic [7:0] status;
  logic irq;
  logic [3:0] ident;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [12:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  ir_int_status #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tmr_zero_i(tmr_zero), .tmr_run_en_i(tmr_run_en), .tmr_irq_en_i(tmr_irq_en),
    .fsf_level_i(fsf_level), .fsf_thresh_i(fsf_thresh), .fsf_timeout_i(fsf_timeout),
    .txf_level_i(txf_level), .txf_thresh_i(txf_thresh),
    .dma_tc_tx_i(dma_tc_tx), .dma_tc_rx_i(dma_tc_rx),
    .hs_toggle_i(hs_toggle), .hs_enable_i(hs_enable), .bit3_en_i(bit3_en),
    .isr_rd_i(isr_rd), .hsr_rd_i(hsr_rd),
    .ien_we_i(ien_we), .ien_wdata_i(ien_wdata),
    .rx_err_i(rx_err), .rx_rdy_i(rx_rdy), .rx_tmo_i(rx_tmo), .tx_emp_i(tx_emp),
    .status_o(status), .irq_o(irq), .ident_o(ident)
  );

  task automatic check_now(input string tag, input logic [12:0] exp);
    logic [12:0] act;
    act = {status, irq, ident};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: status=%h irq=%b ident=%b expected status=%h irq=%b ident=%b",
               tag, act[12:5], act[4], act[3:0], exp[12:5], exp[4], exp[3:0]);
    end
  endtask

  // monitor: compares one queued item after every clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check_now(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic drop_strobes();
    tmr_zero = 0; fsf_timeout = 0; dma_tc_tx = 0; dma_tc_rx = 0;
    hs_toggle = 0; isr_rd = 0; hsr_rd = 0; ien_we = 0;
  endtask

  // driver: inputs are already set; queue expectation, run one cycle
  task automatic cyc(input string tag, input logic [7:0] st, input logic ir,
                     input logic [3:0] id);
    exp_q.push_back({st, ir, id});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    drop_strobes();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    drop_strobes();
    tmr_run_en = 0; tmr_irq_en = 0; hs_enable = 0; bit3_en = 0;
    fsf_level = 0; fsf_thresh = 4; txf_level = 8; txf_thresh = 4;
    ien_wdata = 0; rx_err = 0; rx_rdy = 0; rx_tmo = 0; tx_emp = 0;
    #12;
    check_now("R1 reset state", {8'h00, 1'b0, 4'b0001});
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    cyc("R12 idle low bits zero", 8'h00, 0, 4'b0001);
    // R2 timer gating
    tmr_zero = 1; tmr_run_en = 1;
    cyc("R2 timer blocked by irq enable", 8'h00, 0, 4'b0001);
    tmr_zero = 1; tmr_irq_en = 1;
    cyc("R2 timer sets", 8'h80, 0, 4'b0001);
    cyc("R2 timer holds", 8'h80, 0, 4'b0001);
    isr_rd = 1;
    cyc("R2 timer cleared by status read", 8'h00, 0, 4'b0001);
    // R5 DMA
    dma_tc_rx = 1;
    cyc("R5 dma rx tc sets", 8'h10, 0, 4'b0001);
    cyc("R5 dma holds", 8'h10, 0, 4'b0001);
    isr_rd = 1;
    cyc("R5 dma cleared", 8'h00, 0, 4'b0001);
    dma_tc_tx = 1; isr_rd = 1;
    cyc("R9 set beats read clear", 8'h10, 0, 4'b0001);
    isr_rd = 1;
    cyc("R5 dma cleared after tx tc", 8'h00, 0, 4'b0001);
    // R6 handshake
    hs_enable = 1; bit3_en = 1; hs_toggle = 1;
    cyc("R6 handshake sets", 8'h08, 0, 4'b0001);
    isr_rd = 1;
    cyc("R6 status read keeps handshake", 8'h08, 0, 4'b0001);
    hsr_rd = 1;
    cyc("R6 handshake read clears", 8'h00, 0, 4'b0001);
    // R8 bit 3 visibility
    hs_toggle = 1;
    cyc("R8 handshake set again", 8'h08, 0, 4'b0001);
    bit3_en = 0;
    cyc("R8 bit3 hidden", 8'h00, 0, 4'b0001);
    bit3_en = 1;
    cyc("R8 bit3 visible again", 8'h08, 0, 4'b0001);
    hsr_rd = 1;
    cyc("R6 cleared before enable test", 8'h00, 0, 4'b0001);
    // R7 handshake enable
    hs_enable = 0; hs_toggle = 1;
    cyc("R7 toggle ignored when disabled", 8'h00, 0, 4'b0001);
    hs_enable = 1;
    cyc("R7 nothing pending after enable", 8'h00, 0, 4'b0001);
    hs_toggle = 1;
    cyc("R7 pending event", 8'h08, 0, 4'b0001);
    hs_enable = 0;
    cyc("R7 disable discards", 8'h00, 0, 4'b0001);
    hs_enable = 1;
    cyc("R7 discarded stays gone", 8'h00, 0, 4'b0001);
    // R4 transmit threshold
    txf_level = 3;
    cyc("R4 below threshold", 8'h20, 0, 4'b0001);
    txf_level = 4;
    cyc("R4 equal threshold", 8'h00, 0, 4'b0001);
    txf_level = 5;
    cyc("R4 above threshold", 8'h00, 0, 4'b0001);
    txf_level = 0;
    cyc("R4 empty below", 8'h20, 0, 4'b0001);
    txf_level = 8;
    cyc("R4 follows level back", 8'h00, 0, 4'b0001);
    // R3 frame status FIFO
    fsf_level = 4;
    cyc("R3 level at threshold", 8'h40, 0, 4'b0001);
    fsf_level = 7;
    cyc("R3 level above", 8'h40, 0, 4'b0001);
    fsf_level = 3;
    cyc("R3 level below clears", 8'h00, 0, 4'b0001);
    fsf_level = 0; fsf_timeout = 1;
    cyc("R3 timeout sets", 8'h40, 0, 4'b0001);
    cyc("R3 timeout holds", 8'h40, 0, 4'b0001);
    isr_rd = 1;
    cyc("R3 timeout cleared by read", 8'h00, 0, 4'b0001);
    // R10 interrupt masking
    ien_we = 1; ien_wdata = 5'b00100;
    cyc("R10 enable with no status", 8'h00, 0, 4'b0001);
    txf_level = 0;
    cyc("R10 tx threshold raises irq", 8'h20, 1, 4'b0001);
    ien_we = 1; ien_wdata = 5'b10000;
    cyc("R10 mask removes tx", 8'h20, 0, 4'b0001);
    tmr_zero = 1;
    cyc("R10 timer raises irq", 8'hA0, 1, 4'b0001);
    txf_level = 8; isr_rd = 1;
    cyc("R10 irq drops after clear", 8'h00, 0, 4'b0001);
    // R11 identification priority
    rx_err = 1; rx_rdy = 1;
    cyc("R11 receive status first", 8'h00, 0, 4'b0110);
    rx_err = 0; rx_tmo = 1;
    cyc("R11 ready over timeout", 8'h00, 0, 4'b0100);
    rx_rdy = 0; tx_emp = 1;
    cyc("R11 timeout over tx empty", 8'h00, 0, 4'b1100);
    rx_tmo = 0;
    cyc("R11 tx empty", 8'h00, 0, 4'b0010);
    tx_emp = 0;
    cyc("R11 none pending", 8'h00, 0, 4'b0001);
    // R1 reset mid-run
    dma_tc_rx = 1;
    cyc("R5 dma before reset", 8'h10, 0, 4'b0001);
    txf_level = 0;
    rst_n = 0;
    #1;
    check_now("R1 async reset clears", {8'h00, 1'b0, 4'b0001});
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    cyc("R1 enables cleared by reset", 8'h20, 0, 4'b0001);
    @(posedge clk); #2;
    finish_run();
  end
endmodule